// File: doc/BRIEF.md
# Sixteen-Bit Prescaled Up/Down Event Timer

This block is a 16-bit timer that sits on a simple word-addressed register bus. Software picks a power-of-two clock divider, a count direction and an optional single-shot behaviour. It loads the count and the reload limit while the timer is idle, then starts the timer with a command write. When counting down, the counter reloads from the limit after it passes zero and raises an underflow event. When counting up, it wraps from the limit back to zero and raises an overflow event.

The two events latch into a flag register. Software can set flags through a set alias and clear them through a clear alias. A single level interrupt output is asserted while any flag is set whose enable bit is also set. In single-shot mode the underflow also halts the timer, so one write to the count register followed by a start command gives exactly one timed event. That is the usual way to schedule the next tick. Up-counting with the full limit gives a free-running time base.

Top module: `tmr16_periph`

## Requirements
- R1: After reset every readable register reads zero, the timer is idle and `irq` is low.
- R2: Bus writes take effect at the clock edge where `bus_we` is high, and reads are combinational. The register offsets are: control 0x00, command 0x04, enable 0x0C, flags 0x10, flag-set 0x14, flag-clear 0x18, limit 0x1C, count 0x24. The control register reads back the divider select (bits 27:24), single-shot (bit 4) and direction (bits 1:0). Bits 17:16 choose the clock source. Only the divided core clock exists, so those bits always read zero. Enable, limit and count read back what was written.
- R3: A divider select n moves the count once every 2^n clock cycles while running, for n from 0 to 10. Codes 11 to 15 act as 10. After the start edge, the first step comes 2^n edges later.
- R4: Writing 1 to command bit 0 starts the timer. Writing 1 to bit 1 stops it, and stop wins when both are written. An idle timer holds its count.
- R5: A count write loads the count at once, and after a start the timer steps on from the loaded value.
- R6: Direction code 1 counts down. A step from 0 loads the limit and sets flag bit 1 (underflow).
- R7: Any other direction code counts up. A step from a count equal to the limit gives 0 and sets flag bit 0 (overflow).
- R8: With single-shot set (control bit 4), an underflow leaves the timer idle, holding the reloaded limit.
- R9: A 1 written to the flag-set alias sets the matching flag. A 1 written to the flag-clear alias clears it. A hardware event in the same cycle as a clear keeps the flag set.
- R10: `irq` is high exactly while some flag bit and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Level interrupt request |

## Verification
A write takes effect at the rising edge where its strobe is high. Read data and `irq` follow combinationally from the registers, so the bench samples them at the falling edge that follows. With divider select n, the first count step after a start edge lands 2^n edges later. An underflow or overflow is visible in the count, the flags and `irq` at the falling edge just after the step that causes it. Each directed task counts falling edges from the start write and compares at those exact points. It also checks the cycle before each step, so that a step arriving one edge early or late shows up as a mismatch.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam int SEL_W  = 4;
  localparam int NFLAG  = 2;

  localparam logic [ADDR_W-1:0] OFS_CFG  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CMD  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_FLG  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_FSET = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_FCLR = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_LIM  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 8'h24;

  localparam int SEL_LSB   = 24;
  localparam int SHOT_BIT  = 4;
  localparam int DIR_LSB   = 0;
  localparam int START_BIT = 0;
  localparam int STOP_BIT  = 1;
  localparam int FLAG_OVF  = 0;
  localparam int FLAG_UNF  = 1;

  typedef enum logic [1:0] {
    DIR_UP   = 2'd0,
    DIR_DOWN = 2'd1
  } dir_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int SEL_W   = 4,
  parameter int PRE_MAX = 10,
  localparam int DIV_W  = (PRE_MAX < 1) ? 1 : PRE_MAX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [SEL_W-1:0] sel_eff;
  logic [DIV_W-1:0] lim;
  logic [DIV_W-1:0] div_q, div_d;
  logic             div_en;

  assign sel_eff = (sel > SEL_W'(PRE_MAX)) ? SEL_W'(PRE_MAX) : sel;

  for (genvar g = 0; g < DIV_W; g++) begin : g_mask
    assign lim[g] = (32'(g) < 32'(sel_eff));
  end

  assign tick   = run & ~restart & (div_q == lim);
  assign div_en = restart | run;

  always_comb begin
    if (restart)           div_d = '0;
    else if (div_q == lim) div_d = '0;
    else                   div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (div_en) div_q <= div_d;
  end

  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel_eff != '0) |=> (!tick || sel_eff == '0));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             down,
  input  logic             oneshot,
  input  logic [CNT_W-1:0] top,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             start,
  input  logic             stop,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             ev_uf,
  output logic             ev_of
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             at_zero, at_top, step;

  assign at_zero = (cnt_q == '0);
  assign at_top  = (cnt_q == top);
  assign step    = tick & ~ld_en;
  assign ev_uf   = step & down & at_zero;
  assign ev_of   = step & ~down & at_top;

  always_comb begin
    cnt_d = cnt_q;
    if (ld_en)         cnt_d = ld_val;
    else if (tick) begin
      if (down)        cnt_d = at_zero ? top : cnt_q - 1'b1;
      else             cnt_d = at_top ? '0 : cnt_q + 1'b1;
    end
  end

  always_comb begin
    run_d = run_q;
    if (stop)                      run_d = 1'b0;
    else if (start)                run_d = 1'b1;
    else if (ev_uf && oneshot)     run_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign cnt     = cnt_q;
  assign running = run_q;

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !ld_en) |=> $stable(cnt));
  // R5
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (cnt == $past(ld_val)));
  // R6
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && down && cnt != '0 && !ld_en) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));
  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && down && cnt == '0 && !ld_en) |=> (cnt == $past(top)));
  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !down && cnt == top && !ld_en) |=> (cnt == '0));
  // R8
  oneshot_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_uf && oneshot && !start) |=> !running);
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
  parameter int NFLAG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] hw_set,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic             ien_we,
  input  logic [NFLAG-1:0] wbits,
  output logic [NFLAG-1:0] flags,
  output logic [NFLAG-1:0] ien,
  output logic             irq
);
  logic [NFLAG-1:0] flg_q, flg_d, ien_q;
  logic [NFLAG-1:0] sw_set, sw_clr;

  assign sw_set = set_we ? wbits : '0;
  assign sw_clr = clr_we ? wbits : '0;

  always_comb begin
    flg_d = (flg_q & ~sw_clr) | sw_set | hw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (ien_we) ien_q <= wbits;
  end

  assign flags = flg_q;
  assign ien   = ien_q;
  assign irq   = |(flg_q & ien_q);

  for (genvar k = 0; k < NFLAG; k++) begin : g_chk
    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && wbits[k] && !hw_set[k]) |=> !flags[k]);
    // R9
    flag_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set[k] |=> flags[k]);
  end
endmodule

// File: rtl/tmr16_periph.sv
module tmr16_periph
  import tmr_pkg::*;
#(
  parameter int PRE_MAX = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [SEL_W-1:0] sel_q;
  logic             shot_q;
  logic [1:0]       dir_q;
  logic [CNT_W-1:0] lim_q;

  logic wr_cfg, wr_cmd, wr_ien, wr_fset, wr_fclr, wr_lim, wr_cnt;
  logic cmd_start, cmd_stop, restart, down;
  logic tick, running, ev_uf, ev_of;
  logic [CNT_W-1:0] cnt;
  logic [NFLAG-1:0] flags, ien, hw_set;

  assign wr_cfg  = bus_we && (bus_addr == OFS_CFG);
  assign wr_cmd  = bus_we && (bus_addr == OFS_CMD);
  assign wr_ien  = bus_we && (bus_addr == OFS_IEN);
  assign wr_fset = bus_we && (bus_addr == OFS_FSET);
  assign wr_fclr = bus_we && (bus_addr == OFS_FCLR);
  assign wr_lim  = bus_we && (bus_addr == OFS_LIM);
  assign wr_cnt  = bus_we && (bus_addr == OFS_CNT);

  assign cmd_stop  = wr_cmd & bus_wdata[STOP_BIT];
  assign cmd_start = wr_cmd & bus_wdata[START_BIT] & ~cmd_stop;
  assign restart   = cmd_start;
  assign down      = (dir_q == DIR_DOWN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      shot_q <= 1'b0;
      dir_q  <= DIR_UP;
    end else if (wr_cfg) begin
      sel_q  <= bus_wdata[SEL_LSB +: SEL_W];
      shot_q <= bus_wdata[SHOT_BIT];
      dir_q  <= bus_wdata[DIR_LSB +: 2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lim_q <= '0;
    else if (wr_lim) lim_q <= bus_wdata[CNT_W-1:0];
  end

  tmr_prescale #(.SEL_W(SEL_W), .PRE_MAX(PRE_MAX)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(running), .restart(restart),
    .sel(sel_q), .tick(tick)
  );

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .down(down), .oneshot(shot_q),
    .top(lim_q), .ld_en(wr_cnt), .ld_val(bus_wdata[CNT_W-1:0]),
    .start(cmd_start), .stop(cmd_stop), .cnt(cnt), .running(running),
    .ev_uf(ev_uf), .ev_of(ev_of)
  );

  always_comb begin
    hw_set           = '0;
    hw_set[FLAG_OVF] = ev_of;
    hw_set[FLAG_UNF] = ev_uf;
  end

  tmr_flags #(.NFLAG(NFLAG)) u_flg (
    .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .set_we(wr_fset),
    .clr_we(wr_fclr), .ien_we(wr_ien), .wbits(bus_wdata[NFLAG-1:0]),
    .flags(flags), .ien(ien), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_CFG: begin
        bus_rdata[SEL_LSB +: SEL_W] = sel_q;
        bus_rdata[SHOT_BIT]         = shot_q;
        bus_rdata[DIR_LSB +: 2]     = dir_q;
      end
      OFS_IEN: bus_rdata[NFLAG-1:0] = ien;
      OFS_FLG: bus_rdata[NFLAG-1:0] = flags;
      OFS_LIM: bus_rdata[CNT_W-1:0] = lim_q;
      OFS_CNT: bus_rdata[CNT_W-1:0] = cnt;
      default: bus_rdata = '0;
    endcase
  end

  // R4
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && bus_wdata[STOP_BIT]) |=> !running);
  // R10
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);
endmodule

// File: tb/test_tmr16_periph.sv
module test_tmr16_periph;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int          checks = 0;
  int          errors = 0;

  localparam logic [7:0] A_CFG = 8'h00, A_CMD = 8'h04, A_IEN = 8'h0C,
    A_FLG = 8'h10, A_FSET = 8'h14, A_FCLR = 8'h18, A_LIM = 8'h1C, A_CNT = 8'h24;

  always #10 clk = ~clk;

  tmr16_periph i_tmr16_periph (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset;
    rchk("R1 cfg", A_CFG, 0);
    rchk("R1 ien", A_IEN, 0);
    rchk("R1 flags", A_FLG, 0);
    rchk("R1 lim", A_LIM, 0);
    rchk("R1 cnt", A_CNT, 0);
    chk("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_readback;
    wr(A_CFG, 32'h0A01_0011);
    rchk("R2 cfg readback, clock select zero", A_CFG, 32'h0A00_0011);
    wr(A_IEN, 32'h3);
    rchk("R2 ien", A_IEN, 32'h3);
    wr(A_LIM, 32'h1234_ABCD);
    rchk("R2 lim", A_LIM, 32'h0000_ABCD);
    wr(A_CNT, 32'h0000_BEEF);
    rchk("R2 cnt", A_CNT, 32'h0000_BEEF);
    wr(A_IEN, 0);
  endtask

  task automatic t_prescale;
    wr(A_CMD, 2);
    wr(A_CFG, 32'h0200_0001);
    wr(A_CNT, 100);
    wr(A_CMD, 1);
    rchk("R3 div4 start", A_CNT, 100);
    repeat (3) @(negedge clk);
    rchk("R3 div4 before step", A_CNT, 100);
    @(negedge clk);
    rchk("R3 div4 first step", A_CNT, 99);
    repeat (4) @(negedge clk);
    rchk("R3 div4 second step", A_CNT, 98);
    wr(A_CMD, 2);
    wr(A_CFG, 32'h0F00_0001);
    wr(A_CNT, 50);
    wr(A_CMD, 1);
    repeat (1023) @(negedge clk);
    rchk("R3 code 15 clamps, before step", A_CNT, 50);
    @(negedge clk);
    rchk("R3 code 15 clamps, step at 1024", A_CNT, 49);
    wr(A_CMD, 2);
  endtask

  task automatic t_down(input bit shot);
    wr(A_LIM, 5);
    wr(A_CFG, shot ? 32'h11 : 32'h1);
    wr(A_CNT, 2);
    wr(A_FCLR, 3);
    wr(A_IEN, 2);
    wr(A_CMD, 1);
    rchk("R5 resumes from loaded", A_CNT, 2);
    @(negedge clk); rchk("R6 down step", A_CNT, 1);
    @(negedge clk); rchk("R6 down at zero", A_CNT, 0);
    chk("R6 no flag yet", {31'd0, irq}, 0);
    @(negedge clk); rchk("R6 reload from limit", A_CNT, 5);
    rchk("R6 underflow flag bit1", A_FLG, 2);
    chk("R10 irq on underflow", {31'd0, irq}, 1);
    if (shot) begin
      repeat (3) @(negedge clk);
      rchk("R8 single-shot halted", A_CNT, 5);
    end else begin
      @(negedge clk); rchk("R6 periodic continues", A_CNT, 4);
    end
    wr(A_CMD, 2);
  endtask

  task automatic t_up;
    wr(A_LIM, 3);
    wr(A_CFG, 0);
    wr(A_CNT, 2);
    wr(A_FCLR, 3);
    wr(A_IEN, 1);
    wr(A_CMD, 1);
    @(negedge clk); rchk("R7 up step", A_CNT, 3);
    @(negedge clk); rchk("R7 wrap to zero", A_CNT, 0);
    rchk("R7 overflow flag bit0", A_FLG, 1);
    chk("R10 irq on overflow", {31'd0, irq}, 1);
    @(negedge clk); rchk("R7 after wrap", A_CNT, 1);
  endtask

  task automatic t_stop;
    logic [31:0] a, b;
    wr(A_CMD, 2);
    rd(A_CNT, a);
    repeat (5) @(negedge clk);
    rd(A_CNT, b);
    chk("R4 idle holds count", b, a);
    wr(A_CMD, 3);
    repeat (5) @(negedge clk);
    rchk("R4 stop wins over start", A_CNT, a);
    wr(A_CNT, 7);
    rchk("R5 load while idle", A_CNT, 7);
    wr(A_CMD, 1);
    rchk("R5 start edge keeps value", A_CNT, 7);
    @(negedge clk); rchk("R5 steps from loaded", A_CNT, 8);
    wr(A_CMD, 2);
  endtask

  task automatic t_flags;
    wr(A_FCLR, 3);
    rchk("R9 clear all", A_FLG, 0);
    wr(A_IEN, 0);
    wr(A_FSET, 1);
    rchk("R9 set alias", A_FLG, 1);
    chk("R10 masked flag no irq", {31'd0, irq}, 0);
    wr(A_IEN, 1);
    chk("R10 enabled flag irq", {31'd0, irq}, 1);
    wr(A_FCLR, 1);
    rchk("R9 clear alias", A_FLG, 0);
    chk("R10 irq drops", {31'd0, irq}, 0);
    wr(A_FSET, 2);
    wr(A_LIM, 9);
    wr(A_CFG, 1);
    wr(A_CNT, 1);
    wr(A_CMD, 1);
    wr(A_FCLR, 2);
    rchk("R9 event beats clear", A_FLG, 2);
    rchk("R6 reload to 9", A_CNT, 9);
    wr(A_FCLR, 2);
    rchk("R9 clear without event", A_FLG, 0);
    wr(A_CMD, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_prescale();
    t_down(1'b0);
    t_down(1'b1);
    t_up();
    t_stop();
    t_flags();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule